// File: doc/BRIEF.md
# SIMD Instruction Dispatch Controller

This block is the sequencer of a data-parallel machine. It alone fetches and decodes every instruction of the program; the processing elements of the array cannot fetch or decode. Each fetched word carries a kind bit. A scalar word runs on the controller's own register file and ALU and never reaches the array. An array word is placed unchanged on a shared instruction bus, so that every element applies the same operation to its own local data in the same cycle.

Program memory is read through a port with one cycle of latency. A scalar instruction takes two cycles: one to fetch and one to decode and execute. An array instruction takes a fetch cycle and a decode cycle. It is then held on the broadcast bus until the array signals ready. Fetching stops while the bus waits. Only scalar branches and jumps redirect the program counter. A debug read port exposes the scalar register file.

Top module: `simd_dispatch_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `pm_en` is high, `pm_addr` is 0 and `bcast_valid` is low. `bcast_valid` stays low in the decode cycle that follows, and all scalar registers read 0.
- R2: A fetched word with bit 31 = 1 is an array instruction. In the cycle after its decode, `bcast_valid` goes high and `bcast_instr` equals the fetched word bit for bit.
- R3: A word with bit 31 = 0 is scalar. It never raises `bcast_valid`, and its result is written into the scalar register file.
- R4: While `bcast_valid` is high and `bcast_ready` is low, `bcast_valid` and `bcast_instr` hold their values and `pm_en` stays low.
- R5: In the cycle after a broadcast is accepted (`bcast_valid` and `bcast_ready` both high), `pm_en` is high and `pm_addr` is the address of the broadcast word plus 1.
- R6: Scalar fields are: opcode in bits 30:28, rd in bits 27:24, rs1 in bits 23:20, rs2 in bits 19:16 and imm in bits 15:0. The opcodes are 0 ADD (rs1+rs2), 1 SUB (rs1-rs2), 2 ADDI (rs1 + sign-extended imm), 3 AND, 4 OR and 5 XOR. Each writes its result to rd.
- R7: Opcode 6 (BEQ) writes no register. If rs1 equals rs2, the next fetch is at pc + imm; otherwise it is at pc + 1.
- R8: Opcode 7 (JMP) writes no register. The next fetch is at the low bits of imm.
- R9: Register 0 always reads 0. Writes to it are dropped.
- R10: An array word never writes the register file and never changes control flow, whatever its low 31 bits contain. The next fetch after it is always at its address plus 1.
- R11: Back-to-back scalar instructions are fetched every second cycle: the fetch of the next address comes two cycles after the previous fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pm_en | output | 1 | Program memory read enable |
| pm_addr | output | PC_W | Program memory read address (the program counter) |
| pm_rdata | input | 32 | Program memory read data, valid one cycle after `pm_en` |
| bcast_valid | output | 1 | An array instruction is on the broadcast bus |
| bcast_instr | output | 32 | Broadcast instruction word |
| bcast_ready | input | 1 | The array accepts the broadcast word this cycle |
| dbg_raddr | input | log2(NREG) | Scalar register debug read address |
| dbg_rdata | output | DATA_W | Scalar register debug read data |

## Verification
The bench aims at array words whose low bits look like a scalar ADDI or JMP. A decoder that ignored the kind bit would write a register or jump, and both are visible afterwards. It holds the array's ready low for several cycles. A controller that dropped the word, changed it or kept fetching would show a changing bus or an early `pm_en`. Branches are taken and not taken, immediates are negative, and register 0 is written on purpose. These cases catch a wrong branch base or offset, a missing sign extension and a writable zero register as wrong register values.

// File: rtl/sdc_pkg.sv
`timescale 1ns/1ps
package sdc_pkg;
   localparam int INSTR_W  = 32;
   localparam int KIND_BIT = 31;
   localparam int OP_LSB   = 28;
   localparam int RD_LSB   = 24;
   localparam int RS1_LSB  = 20;
   localparam int RS2_LSB  = 16;
   localparam int IMM_W    = 16;
   localparam int FIELD_W  = 4;

   typedef enum logic [2:0] {
      SOP_ADD  = 3'd0,
      SOP_SUB  = 3'd1,
      SOP_ADDI = 3'd2,
      SOP_AND  = 3'd3,
      SOP_OR   = 3'd4,
      SOP_XOR  = 3'd5,
      SOP_BEQ  = 3'd6,
      SOP_JMP  = 3'd7
   } sop_e;

   typedef enum logic [1:0] {
      ST_FETCH  = 2'd0,
      ST_DECODE = 2'd1,
      ST_BCAST  = 2'd2
   } seq_st_e;
endpackage

// File: rtl/sdc_decoder.sv
`timescale 1ns/1ps
module sdc_decoder
   import sdc_pkg::*;
#(
   parameter int RA_W = 4
) (
   input  logic [INSTR_W-1:0] instr,
   output logic               is_array,
   output sop_e               op,
   output logic [RA_W-1:0]    rd,
   output logic [RA_W-1:0]    rs1,
   output logic [RA_W-1:0]    rs2,
   output logic [IMM_W-1:0]   imm
);
   assign is_array = instr[KIND_BIT];
   assign op       = sop_e'(instr[OP_LSB +: 3]);
   assign rd       = instr[RD_LSB  +: RA_W];
   assign rs1      = instr[RS1_LSB +: RA_W];
   assign rs2      = instr[RS2_LSB +: RA_W];
   assign imm      = instr[IMM_W-1:0];
endmodule

// File: rtl/sdc_scalar_alu.sv
`timescale 1ns/1ps
module sdc_scalar_alu
   import sdc_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int PC_W   = 8
) (
   input  sop_e              op,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic [IMM_W-1:0]  imm,
   input  logic [PC_W-1:0]   pc,
   output logic              wr_en,
   output logic [DATA_W-1:0] wr_data,
   output logic [PC_W-1:0]   pc_next
);
   logic [DATA_W-1:0] simm;
   logic [PC_W-1:0]   imm_pc;

   assign simm   = DATA_W'($signed(imm));
   assign imm_pc = imm[PC_W-1:0];

   always_comb begin
      wr_en   = 1'b1;
      wr_data = '0;
      pc_next = pc + 1'b1;
      unique case (op)
         SOP_ADD:  wr_data = a + b;
         SOP_SUB:  wr_data = a - b;
         SOP_ADDI: wr_data = a + simm;
         SOP_AND:  wr_data = a & b;
         SOP_OR:   wr_data = a | b;
         SOP_XOR:  wr_data = a ^ b;
         SOP_BEQ: begin
            wr_en = 1'b0;
            if (a == b) pc_next = pc + imm_pc;
         end
         SOP_JMP: begin
            wr_en   = 1'b0;
            pc_next = imm_pc;
         end
         default: wr_en = 1'b0;
      endcase
   end
endmodule

// File: rtl/sdc_regfile.sv
`timescale 1ns/1ps
module sdc_regfile #(
   parameter int DATA_W  = 32,
   parameter int NREG    = 16,
   parameter bit ZERO_R0 = 1'b1,
   localparam int RA_W   = $clog2(NREG)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [RA_W-1:0]   waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [RA_W-1:0]   ra_a,
   input  logic [RA_W-1:0]   ra_b,
   input  logic [RA_W-1:0]   ra_dbg,
   output logic [DATA_W-1:0] rd_a,
   output logic [DATA_W-1:0] rd_b,
   output logic [DATA_W-1:0] rd_dbg
);
   logic [DATA_W-1:0] bank [NREG];

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      if (ZERO_R0 && i == 0) begin : g_zero
         assign bank[i] = '0;
      end else begin : g_store
         logic [DATA_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else if (we && waddr == RA_W'(i)) q <= wdata;
         end
         assign bank[i] = q;
      end
   end

   assign rd_a   = bank[ra_a];
   assign rd_b   = bank[ra_b];
   assign rd_dbg = bank[ra_dbg];
endmodule

// File: rtl/simd_dispatch_ctrl.sv
`timescale 1ns/1ps
module simd_dispatch_ctrl
   import sdc_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int NREG    = 16,
   parameter int PC_W    = 8,
   parameter bit ZERO_R0 = 1'b1,
   localparam int RA_W   = $clog2(NREG)
) (
   input  logic               clk,
   input  logic               rst_n,
   output logic               pm_en,
   output logic [PC_W-1:0]    pm_addr,
   input  logic [INSTR_W-1:0] pm_rdata,
   output logic               bcast_valid,
   output logic [INSTR_W-1:0] bcast_instr,
   input  logic               bcast_ready,
   input  logic [RA_W-1:0]    dbg_raddr,
   output logic [DATA_W-1:0]  dbg_rdata
);
   if (NREG < 2 || NREG > (1 << FIELD_W) || (NREG & (NREG - 1)) != 0) begin : g_bad_nreg
      $error("NREG must be a power of two from 2 to 16");
   end
   if (DATA_W < IMM_W) begin : g_bad_data_w
      $error("DATA_W must be at least the immediate width");
   end
   if (PC_W < 1 || PC_W > IMM_W) begin : g_bad_pc_w
      $error("PC_W must lie between 1 and the immediate width");
   end

   seq_st_e              state_q, state_d;
   logic [PC_W-1:0]      pc_q, pc_d;
   logic [INSTR_W-1:0]   ir_q, ir_d;

   logic                 dec_is_array;
   sop_e                 dec_op;
   logic [RA_W-1:0]      dec_rd, dec_rs1, dec_rs2;
   logic [IMM_W-1:0]     dec_imm;

   logic [DATA_W-1:0]    opnd_a, opnd_b;
   logic                 alu_we;
   logic [DATA_W-1:0]    alu_data;
   logic [PC_W-1:0]      alu_pc_next;
   logic                 rf_we;

   sdc_decoder #(.RA_W(RA_W)) u_dec (
      .instr    (pm_rdata),
      .is_array (dec_is_array),
      .op       (dec_op),
      .rd       (dec_rd),
      .rs1      (dec_rs1),
      .rs2      (dec_rs2),
      .imm      (dec_imm)
   );

   sdc_regfile #(.DATA_W(DATA_W), .NREG(NREG), .ZERO_R0(ZERO_R0)) u_rf (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (rf_we),
      .waddr  (dec_rd),
      .wdata  (alu_data),
      .ra_a   (dec_rs1),
      .ra_b   (dec_rs2),
      .ra_dbg (dbg_raddr),
      .rd_a   (opnd_a),
      .rd_b   (opnd_b),
      .rd_dbg (dbg_rdata)
   );

   sdc_scalar_alu #(.DATA_W(DATA_W), .PC_W(PC_W)) u_alu (
      .op      (dec_op),
      .a       (opnd_a),
      .b       (opnd_b),
      .imm     (dec_imm),
      .pc      (pc_q),
      .wr_en   (alu_we),
      .wr_data (alu_data),
      .pc_next (alu_pc_next)
   );

   always_comb begin
      state_d = state_q;
      pc_d    = pc_q;
      ir_d    = ir_q;
      rf_we   = 1'b0;
      unique case (state_q)
         ST_FETCH: state_d = ST_DECODE;
         ST_DECODE: begin
            if (dec_is_array) begin
               ir_d    = pm_rdata;
               state_d = ST_BCAST;
            end else begin
               rf_we   = alu_we;
               pc_d    = alu_pc_next;
               state_d = ST_FETCH;
            end
         end
         ST_BCAST: begin
            if (bcast_ready) begin
               pc_d    = pc_q + 1'b1;
               state_d = ST_FETCH;
            end
         end
         default: state_d = ST_FETCH;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_FETCH;
         pc_q    <= '0;
         ir_q    <= '0;
      end else begin
         state_q <= state_d;
         pc_q    <= pc_d;
         ir_q    <= ir_d;
      end
   end

   assign pm_en       = (state_q == ST_FETCH);
   assign pm_addr     = pc_q;
   assign bcast_valid = (state_q == ST_BCAST);
   assign bcast_instr = ir_q;
endmodule

// File: rtl/sdc_checker.sv
`timescale 1ns/1ps
module sdc_checker #(
   parameter int DATA_W  = 32,
   parameter int PC_W    = 8,
   parameter int RA_W    = 4,
   parameter bit ZERO_R0 = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              pm_en,
   input logic [PC_W-1:0]   pm_addr,
   input logic              bcast_valid,
   input logic [31:0]       bcast_instr,
   input logic              bcast_ready,
   input logic              dec_is_array,
   input logic              rf_we,
   input logic [RA_W-1:0]   dbg_raddr,
   input logic [DATA_W-1:0] dbg_rdata
);
   // R1
   first_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (pm_en && pm_addr == '0 && !bcast_valid));

   // R2
   bcast_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bcast_valid |-> bcast_instr[31]);

   // R3
   bcast_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bcast_valid) |-> $past(dec_is_array));

   // R4
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bcast_valid && !bcast_ready) |=> (bcast_valid && $stable(bcast_instr)));

   // R4
   stall_nofetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bcast_valid |-> !pm_en);

   // R5
   accept_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bcast_valid && bcast_ready) |=> (pm_en && pm_addr == PC_W'($past(pm_addr) + 1'b1)));

   // R10
   array_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dec_is_array |-> !rf_we);

   if (ZERO_R0) begin : g_r0
      // R9
      zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (dbg_raddr == '0) |-> (dbg_rdata == '0));
   end
endmodule

bind simd_dispatch_ctrl sdc_checker #(
   .DATA_W(DATA_W), .PC_W(PC_W), .RA_W(RA_W), .ZERO_R0(ZERO_R0)
) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .pm_en        (pm_en),
   .pm_addr      (pm_addr),
   .bcast_valid  (bcast_valid),
   .bcast_instr  (bcast_instr),
   .bcast_ready  (bcast_ready),
   .dec_is_array (dec_is_array),
   .rf_we        (rf_we),
   .dbg_raddr    (dbg_raddr),
   .dbg_rdata    (dbg_rdata)
);

// File: tb/simd_dispatch_ctrl_tb_top.sv
`timescale 1ns/1ps
module simd_dispatch_ctrl_tb_top;
   import sdc_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pm_en;
   logic [7:0]  pm_addr;
   logic [31:0] pm_rdata = '0;
   logic        bcast_valid;
   logic [31:0] bcast_instr;
   logic        bcast_ready = 1'b0;
   logic [3:0]  dbg_raddr = '0;
   logic [31:0] dbg_rdata;

   logic [31:0] mem [16];
   int          nchk = 0;
   int          nerr = 0;
   int          bseen = 0;
   bit          timed_out = 1'b0;

   always #2.5 clk = ~clk;

   simd_dispatch_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .pm_en(pm_en), .pm_addr(pm_addr),
      .pm_rdata(pm_rdata), .bcast_valid(bcast_valid), .bcast_instr(bcast_instr),
      .bcast_ready(bcast_ready), .dbg_raddr(dbg_raddr), .dbg_rdata(dbg_rdata)
   );

   always_ff @(posedge clk) if (pm_en) pm_rdata <= mem[pm_addr[3:0]];

   always @(negedge clk) if (rst_n && bcast_valid) bseen++;

   // {opcode, operand a, operand b, expected rd}
   localparam logic [66:0] VEC [8] = '{
      {3'd0, 16'd5,    16'd7,    32'd12},
      {3'd0, 16'hFFFF, 16'h0001, 32'h0},
      {3'd1, 16'd3,    16'd5,    32'hFFFF_FFFE},
      {3'd2, 16'd10,   16'hFFFB, 32'd5},
      {3'd3, 16'h00F0, 16'h0FF0, 32'h0000_00F0},
      {3'd4, 16'h00F0, 16'h0F0F, 32'h0000_0FFF},
      {3'd5, 16'hFFFF, 16'h00FF, 32'hFFFF_FF00},
      {3'd5, 16'h1234, 16'h1234, 32'h0}
   };

   function automatic logic [31:0] enc(sop_e op, int rd, int rs1, int rs2, logic [15:0] imm);
      return {1'b0, op, 4'(rd), 4'(rs1), 4'(rs2), imm};
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic clear_mem();
      for (int i = 0; i < 16; i++) mem[i] = enc(SOP_JMP, 0, 0, 0, 16'(i));
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      bcast_ready = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic rd_reg(input int idx, output logic [31:0] val);
      @(negedge clk);
      dbg_raddr = 4'(idx);
      #1;
      val = dbg_rdata;
   endtask

   task automatic run_tests();
      logic [31:0] v;
      int base;
      logic held;

      // ALU vector table
      for (int k = 0; k < 8; k++) begin
         clear_mem();
         mem[0] = enc(SOP_ADDI, 1, 0, 0, VEC[k][63:48]);
         mem[1] = enc(SOP_ADDI, 2, 0, 0, VEC[k][47:32]);
         mem[2] = enc(sop_e'(VEC[k][66:64]), 3, 1, 2, VEC[k][47:32]);
         mem[3] = enc(SOP_JMP, 0, 0, 0, 16'd3);
         do_reset();
         base = bseen;
         repeat (16) @(negedge clk);
         rd_reg(3, v);
         check($sformatf("R6 vector %0d", k), v, VEC[k][31:0]);
         check("R3 scalar run raised no broadcast", 32'(bseen - base), 32'd0);
      end

      // Reset state and array broadcast with stall
      clear_mem();
      mem[0] = 32'hA500_0007;
      mem[1] = 32'hF500_0009;
      mem[2] = enc(SOP_ADDI, 4, 0, 0, 16'd9);
      mem[3] = enc(SOP_JMP, 0, 0, 0, 16'd3);
      do_reset();
      #1;
      check("R1 first fetch en/addr/valid", {22'd0, pm_en, pm_addr, bcast_valid}, {22'd0, 1'b1, 8'd0, 1'b0});
      @(negedge clk);
      check("R1 no broadcast in decode", {31'd0, bcast_valid}, 32'd0);
      @(negedge clk);
      check("R2 first broadcast word", bcast_valid ? bcast_instr : 32'hDEAD_BEEF, 32'hA500_0007);
      held = 1'b1;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         if (!bcast_valid || bcast_instr !== 32'hA500_0007 || pm_en) held = 1'b0;
      end
      check("R4 bus held and fetch stalled", {31'd0, held}, 32'd1);
      bcast_ready = 1'b1;
      @(negedge clk);
      bcast_ready = 1'b0;
      check("R5 fetch after accept", {23'd0, pm_en, pm_addr}, {23'd0, 1'b1, 8'd1});
      repeat (2) @(negedge clk);
      check("R2 second broadcast word", bcast_valid ? bcast_instr : 32'hDEAD_BEEF, 32'hF500_0009);
      bcast_ready = 1'b1;
      @(negedge clk);
      check("R10 jump-like array word not taken", {23'd0, pm_en, pm_addr}, {23'd0, 1'b1, 8'd2});
      repeat (10) @(negedge clk);
      rd_reg(5, v);
      check("R10 array word wrote no register", v, 32'd0);
      rd_reg(4, v);
      check("R3 scalar result after broadcasts", v, 32'd9);

      // Branches
      clear_mem();
      mem[0] = enc(SOP_ADDI, 1, 0, 0, 16'd4);
      mem[1] = enc(SOP_ADDI, 2, 0, 0, 16'd4);
      mem[2] = enc(SOP_BEQ, 0, 1, 2, 16'd3);
      mem[3] = enc(SOP_ADDI, 6, 0, 0, 16'd1);
      mem[4] = enc(SOP_JMP, 0, 0, 0, 16'd4);
      mem[5] = enc(SOP_ADDI, 7, 0, 0, 16'd2);
      mem[6] = enc(SOP_BEQ, 0, 1, 0, 16'd5);
      mem[7] = enc(SOP_ADDI, 8, 0, 0, 16'd3);
      mem[8] = enc(SOP_ADDI, 9, 0, 0, 16'hFFFE);
      mem[9] = enc(SOP_BEQ, 0, 0, 0, 16'd3);
      do_reset();
      repeat (30) @(negedge clk);
      rd_reg(6, v);
      check("R7 taken branch skipped word", v, 32'd0);
      rd_reg(7, v);
      check("R7 taken branch target", v, 32'd2);
      rd_reg(8, v);
      check("R7 not-taken falls through", v, 32'd3);
      rd_reg(9, v);
      check("R6 ADDI negative immediate", v, 32'hFFFF_FFFE);

      // Jump
      clear_mem();
      mem[0] = enc(SOP_JMP, 0, 0, 0, 16'd6);
      mem[1] = enc(SOP_ADDI, 9, 0, 0, 16'd1);
      mem[6] = enc(SOP_ADDI, 10, 0, 0, 16'd5);
      mem[7] = enc(SOP_JMP, 0, 0, 0, 16'd7);
      do_reset();
      #1;
      @(negedge clk);
      @(negedge clk);
      check("R8 jump target fetched", {23'd0, pm_en, pm_addr}, {23'd0, 1'b1, 8'd6});
      repeat (10) @(negedge clk);
      rd_reg(9, v);
      check("R8 skipped word not run", v, 32'd0);
      rd_reg(10, v);
      check("R8 target word ran", v, 32'd5);

      // Zero register and scalar cadence
      clear_mem();
      mem[0] = enc(SOP_ADDI, 0, 0, 0, 16'd9);
      mem[1] = enc(SOP_ADD, 11, 0, 0, 16'd0);
      mem[2] = enc(SOP_ADDI, 12, 0, 0, 16'd1);
      mem[3] = enc(SOP_JMP, 0, 0, 0, 16'd3);
      do_reset();
      #1;
      check("R11 fetch at 0", {23'd0, pm_en, pm_addr}, {23'd0, 1'b1, 8'd0});
      @(negedge clk);
      check("R11 no fetch in execute cycle", {31'd0, pm_en}, 32'd0);
      @(negedge clk);
      check("R11 next fetch two cycles later", {23'd0, pm_en, pm_addr}, {23'd0, 1'b1, 8'd1});
      repeat (10) @(negedge clk);
      rd_reg(0, v);
      check("R9 register 0 reads zero", v, 32'd0);
      rd_reg(11, v);
      check("R9 write to register 0 dropped", v, 32'd0);
      rd_reg(12, v);
      check("R3 scalar write", v, 32'd1);

      // Reset clears registers
      rst_n = 1'b0;
      #1;
      dbg_raddr = 4'd12;
      #1;
      check("R1 registers cleared by reset", dbg_rdata, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      clear_mem();
      fork
         run_tests();
         begin
            repeat (150000) @(negedge clk);
            timed_out = 1'b1;
         end
      join_any
      disable fork;
      if (timed_out) begin
         nchk++;
         nerr++;
         $display("FAIL watchdog: actual=timeout expected=completion");
      end
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end
endmodule